// File: doc/BRIEF.md
# Strip-Mined Integer Sum Reducer

The block adds a long stream of 32-bit integers down to one total. The stream arrives in chunks of up to eight elements. In the accumulate phase, each chunk is added lane by lane into a bank of eight partial sums. The bank is set to zero when a job begins. When the chunk flagged as last has been taken in, the block folds the bank in half three times. Each fold adds the upper half of the live lanes into the lower half. After the third fold, lane zero holds the total.

A job starts with a one-cycle `start` pulse. Chunks then follow with `in_valid`, and each chunk carries a count of how many of its lanes are real. Three cycles after the last chunk is accepted, `done` pulses and `sum` shows the total. `sum` keeps that value until the next `start`.

Top module: `vsum_halving`

## Requirements
- R1: After reset, `sum` is 0 and `done` is 0.
- R2: `start` sets the partial sums and `sum` to zero. It aborts any job in progress, including one in the fold phase, so that job never raises `done`. From the next cycle, `sum` reads 0.
- R3: An accepted chunk adds lane i of `in_data` (bits 32*i+31 down to 32*i) into partial sum i, but only for i < `in_count`. Lanes at or above `in_count` add zero. An `in_count` of 0 adds nothing.
- R4: A chunk is accepted only while a job is accumulating. Chunks presented while the block is idle or folding have no effect on `done` or on `sum`.
- R5: `done` goes high in the third cycle after the clock edge that accepts the chunk with `in_last` set. One fold happens per cycle. `sum` then equals the total of all accepted lanes.
- R6: `done` lasts exactly one cycle. `sum` holds the result until the next `start`.
- R7: When `start` and `in_valid` are high in the same cycle, `start` wins and that chunk is discarded.
- R8: All additions are 32-bit two's complement and wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new job, clearing all state |
| in_valid | input | 1 | A chunk is present on `in_data` |
| in_last | input | 1 | This chunk is the final one of the job |
| in_count | input | 4 | Number of valid lanes in the chunk, 0 to 8 |
| in_data | input | 256 | Eight 32-bit lanes, lane i at bits 32*i+31:32*i |
| sum | output | 32 | Total of the most recent finished job |
| done | output | 1 | One-cycle pulse when `sum` becomes valid |

## Verification
Two functions can land on the same clock edge: a fresh `start` and the intake of a chunk, or a `start` and an unfinished fold phase. The bench raises `start` together with a valid chunk, and judges the case by checking that the following job's total leaves that chunk out. It also raises `start` in the cycle after the last chunk is accepted, and judges that case by checking that `sum` drops to zero and that `done` stays low through the cycles where the aborted fold would have finished. The bench further sweeps chunk counts and final-chunk lane counts, and compares each total with a sum it computes arithmetically modulo 2^32.

// File: rtl/vsum_halving.sv
module vsum_halving #(
  parameter int LANES = 8,
  parameter int W     = 32,
  parameter int CW    = $clog2(LANES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic [CW-1:0]      in_count,
  input  logic [LANES*W-1:0] in_data,
  output logic [W-1:0]       sum,
  output logic               done
);
  localparam int HALF = LANES / 2;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_ACC = 2'd1, S_FOLD = 2'd2} state_t;

  state_t        st;
  logic [W-1:0]  part [LANES];
  logic [CW-1:0] len;
  logic [CW-1:0] half;

  assign half = len >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      len  <= '0;
      sum  <= '0;
      done <= 1'b0;
      for (int i = 0; i < LANES; i++) part[i] <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        st  <= S_ACC;
        len <= CW'(LANES);
        sum <= '0;
        for (int i = 0; i < LANES; i++) part[i] <= '0;
      end else begin
        case (st)
          S_ACC: if (in_valid) begin
            for (int i = 0; i < LANES; i++)
              if (CW'(i) < in_count) part[i] <= part[i] + in_data[i*W +: W];
            if (in_last) st <= S_FOLD;
          end
          S_FOLD: begin
            for (int i = 0; i < HALF; i++)
              if (CW'(i) < half) part[i] <= part[i] + part[i + int'(half)];
            len <= half;
            if (half == CW'(1)) begin
              st   <= S_IDLE;
              done <= 1'b1;
              sum  <= part[0] + part[1];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module vsum_halving_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic [1:0]   st,
  input logic [W-1:0] sum
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && sum == '0));

  a_r5_done_after_fold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(st) == 2'd2 && !$past(start)));

  a_r6_sum_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && st != 2'd2) |=> $stable(sum));

  a_r4_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !start) |=> (st == 2'd0 && !done));
endmodule

bind vsum_halving vsum_halving_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .st(st), .sum(sum)
);

// File: tb/vsum_halving_tb.sv
module vsum_halving_tb;
  localparam int LANES = 8;
  localparam int W     = 32;
  localparam int CW    = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_last = 1'b0;
  logic [CW-1:0]      in_count = '0;
  logic [LANES*W-1:0] in_data = '0;
  logic [W-1:0]       sum;
  logic               done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vsum_halving u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_last(in_last), .in_count(in_count), .in_data(in_data),
    .sum(sum), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] val(int seed, int c, int i);
    return 32'(seed) * 32'h9E3779B1 + 32'(c) * 32'h01000193 + 32'(i) * 32'h7FFFFFFF;
  endfunction

  task automatic put_chunk(int seed, int c, int cnt, bit last, output logic [31:0] part);
    part = '0;
    for (int i = 0; i < LANES; i++) begin
      in_data[i*W +: W] = val(seed, c, i);
      if (i < cnt) part += val(seed, c, i);
    end
    in_valid = 1'b1;
    in_last  = last;
    in_count = CW'(cnt);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(sum == '0 && !done, "R2", sum, 0);
  endtask

  task automatic run_job(int nch, int lastcnt, int seed);
    logic [31:0] exp, p;
    exp = '0;
    pulse_start();
    for (int c = 0; c < nch; c++) begin
      put_chunk(seed, c, (c == nch - 1) ? lastcnt : LANES, c == nch - 1, p);
      exp += p;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    chk(!done, "R5", 32'(done), 0);
    @(negedge clk);
    chk(!done, "R5", 32'(done), 0);
    @(negedge clk);
    chk(done, "R5", 32'(done), 1);
    chk(sum == exp, "R3", sum, exp);
    @(negedge clk);
    chk(!done, "R6", 32'(done), 0);
    chk(sum == exp, "R6", sum, exp);
  endtask

  initial begin
    for (int k = 0; k < 100000; k++) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp, p, held;
    repeat (3) @(negedge clk);
    chk(sum == '0 && !done, "R1", sum, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sum == '0 && !done, "R1", sum, 0);

    // R3 R5 R8: sweep of chunk counts and final-chunk lane counts
    for (int n = 1; n <= 4; n++)
      for (int lc = 0; lc <= LANES; lc++)
        run_job(n, lc, n * 16 + lc);

    // R8: explicit wrap
    pulse_start();
    in_data = '0;
    for (int i = 0; i < LANES; i++) in_data[i*W +: W] = 32'hFFFF_FFFF;
    in_valid = 1'b1; in_last = 1'b1; in_count = CW'(LANES);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    chk(done && sum == 32'hFFFF_FFF8, "R8", sum, 32'hFFFF_FFF8);

    // R7: start together with a chunk drops the chunk
    put_chunk(99, 0, LANES, 1'b0, p);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    put_chunk(5, 1, 3, 1'b1, exp);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    chk(done && sum == exp, "R7", sum, exp);

    // R4: chunks while idle are ignored
    held = sum;
    @(negedge clk);
    put_chunk(7, 0, LANES, 1'b1, p);
    repeat (6) begin
      @(negedge clk);
      chk(!done && sum == held, "R4", sum, held);
    end
    in_valid = 1'b0; in_last = 1'b0;

    // R4: chunks during folding are ignored
    pulse_start();
    put_chunk(11, 0, LANES, 1'b1, exp);
    @(negedge clk);
    put_chunk(12, 1, LANES, 1'b0, p);
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(done && sum == exp, "R4", sum, exp);

    // R2: start during folding aborts the job
    pulse_start();
    put_chunk(13, 0, LANES, 1'b1, p);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) begin
      chk(!done && sum == '0, "R2", sum, 0);
      @(negedge clk);
    end
    run_job(2, 5, 777);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule